// File: doc/BRIEF.md
# Posted-Write Queue with Read Forwarding

This block sits below a write-through cache and above the next memory level. Every word write from the cache is posted into a small queue, so the processor does not wait on memory write latency. Posted writes leave the queue strictly oldest first over a request/acknowledge port to the next level. A queue of several slots, rather than one holding register, absorbs the bursts in which writes usually arrive.

Each read miss on its way to memory is first compared against every queued entry. The youngest entry with the same word address decides the outcome. If it covers all four bytes, its data is returned in the same cycle and memory is not touched. If it covers only some bytes, the read waits while draining continues, until no queued entry holds that address. If nothing matches, the read goes out on the next-level port ahead of any pending drain. A read therefore never sees stale data and never queues behind unrelated writes.

Top module: `wr_drain_buf`

## Requirements
- R1: After reset the queue is empty, `wr_stall` is 0, `mem_req` is 0 while `rd_valid` is 0, and `rd_ack` and `rd_wait` are 0.
- R2: A write with `wr_valid`=1 and `wr_stall`=0 is queued at the clock edge. Queued entries are presented on the next-level port with `mem_we`=1 strictly in arrival order. An entry leaves on a cycle where it is presented and `mem_ack`=1. A presented drain keeps its address stable until it is acknowledged or a read takes the port.
- R3: With all DEPTH (default 4) slots occupied, `wr_stall` is 1 and a write offered with `wr_valid`=1 is dropped, never drained. `wr_stall` stays 1 until an entry drains.
- R4: Writes to an address that is already queued are never merged. Each one becomes its own entry and drains separately.
- R5: When the youngest queued entry whose address equals `rd_addr` has `be`=4'b1111, `rd_ack`=1 and `rd_data` is that entry's data in the same cycle, with no read on the next-level port. This holds even if older entries to that address carry partial byte enables.
- R6: When the youngest matching entry has a byte enable other than 4'b1111, `rd_wait`=1 and `rd_ack`=0 until no queued entry matches. After that, the read proceeds as in R7.
- R7: A read with no matching entry is issued at once on the next-level port (`mem_req`=1, `mem_we`=0, `mem_addr`=`rd_addr`), even when drains are pending. `rd_ack` follows `mem_ack` and `rd_data` follows `mem_rdata`.
- R8: While a read is held by R6, the next-level port keeps draining queued writes.
- R9: The search covers only entries queued before the current cycle. A write accepted in the same cycle as a read to its address is invisible to that read, and is visible from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Write offered by the cache |
| wr_addr | input | 32 | Word address of the write |
| wr_data | input | 32 | Write data |
| wr_be | input | 4 | Byte enables of the write |
| wr_stall | output | 1 | Queue full, offered write not taken |
| rd_valid | input | 1 | Read miss requesting data |
| rd_addr | input | 32 | Word address of the read |
| rd_ack | output | 1 | Read data valid this cycle |
| rd_wait | output | 1 | Read held by a partial queued write |
| rd_data | output | 32 | Read data (forwarded or from memory) |
| mem_req | output | 1 | Next-level request |
| mem_we | output | 1 | 1 for a drain, 0 for a read |
| mem_addr | output | 32 | Next-level word address |
| mem_wdata | output | 32 | Drain data |
| mem_be | output | 4 | Drain byte enables (all ones for reads) |
| mem_ack | input | 1 | Next level accepts the request this cycle |
| mem_rdata | input | 32 | Next-level read data, valid with `mem_ack` on a read |

## Verification
The hardest case to reach is a read whose address is queued twice, once with full and once with partial byte enables. Only the age order of those two entries decides between forwarding and waiting. The stimulus holds `mem_ack` low so entries pile up in a known order, then issues the read and releases the acknowledge one cycle at a time. This shows the read wait through the first drain, resolve after the second, and then take the port ahead of nothing. A separate scenario fills the queue completely and offers a fifth write, then counts the drains to prove that the fifth write was dropped.

// File: rtl/wrbuf_pkg.sv
package wrbuf_pkg;
    parameter int WB_AW  = 32;
    parameter int WB_DW  = 32;
    localparam int WB_BEW = WB_DW / 8;

    typedef struct packed {
        logic [WB_AW-1:0]  addr;
        logic [WB_DW-1:0]  data;
        logic [WB_BEW-1:0] be;
    } wb_entry_t;
endpackage

// File: rtl/wrbuf_lookup.sv
module wrbuf_lookup
    import wrbuf_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int PTRW = $clog2(DEPTH),
    localparam int CNTW = $clog2(DEPTH + 1)
) (
    input  wb_entry_t [DEPTH-1:0] ent,
    input  logic [PTRW-1:0]       head,
    input  logic [CNTW-1:0]       cnt,
    input  logic [WB_AW-1:0]      rd_addr,
    output logic                  any_match,
    output logic                  full_cover,
    output logic [WB_DW-1:0]      fwd_data
);
    logic [DEPTH-1:0] slot_hit;

    // one comparator per slot; a slot is live when its age is below cnt
    for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
        logic [PTRW-1:0] age;
        assign age = PTRW'(i) - head;
        assign slot_hit[i] = ({1'b0, age} < (PTRW+1)'(cnt)) && (ent[i].addr == rd_addr);
    end

    // walk from oldest to youngest; the last hit is the youngest
    always_comb begin
        logic [PTRW-1:0] sel;
        any_match = 1'b0;
        sel       = '0;
        for (int k = 0; k < DEPTH; k++) begin
            logic [PTRW-1:0] slot;
            slot = head + PTRW'(k);
            if (slot_hit[slot]) begin
                any_match = 1'b1;
                sel       = slot;
            end
        end
        full_cover = &ent[sel].be;
        fwd_data   = ent[sel].data;
    end
endmodule

// File: rtl/wrbuf_port_arb.sv
module wrbuf_port_arb
    import wrbuf_pkg::*;
(
    input  logic              rd_valid,
    input  logic              rd_match,
    input  logic [WB_AW-1:0]  rd_addr,
    input  logic              have_entry,
    input  wb_entry_t         head_ent,
    input  logic              mem_ack,
    output logic              mem_req,
    output logic              mem_we,
    output logic [WB_AW-1:0]  mem_addr,
    output logic [WB_DW-1:0]  mem_wdata,
    output logic [WB_BEW-1:0] mem_be,
    output logic              rd_go,
    output logic              drain_done
);
    always_comb begin
        rd_go      = rd_valid && !rd_match;
        mem_req    = 1'b0;
        mem_we     = 1'b0;
        mem_addr   = '0;
        mem_wdata  = '0;
        mem_be     = '0;
        drain_done = 1'b0;
        if (rd_go) begin
            mem_req  = 1'b1;
            mem_addr = rd_addr;
            mem_be   = '1;
        end else if (have_entry) begin
            mem_req    = 1'b1;
            mem_we     = 1'b1;
            mem_addr   = head_ent.addr;
            mem_wdata  = head_ent.data;
            mem_be     = head_ent.be;
            drain_done = mem_ack;
        end
    end
endmodule

// File: rtl/wr_drain_buf.sv
module wr_drain_buf
    import wrbuf_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int PTRW = $clog2(DEPTH),
    localparam int CNTW = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [WB_AW-1:0]  wr_addr,
    input  logic [WB_DW-1:0]  wr_data,
    input  logic [WB_BEW-1:0] wr_be,
    output logic              wr_stall,
    input  logic              rd_valid,
    input  logic [WB_AW-1:0]  rd_addr,
    output logic              rd_ack,
    output logic              rd_wait,
    output logic [WB_DW-1:0]  rd_data,
    output logic              mem_req,
    output logic              mem_we,
    output logic [WB_AW-1:0]  mem_addr,
    output logic [WB_DW-1:0]  mem_wdata,
    output logic [WB_BEW-1:0] mem_be,
    input  logic              mem_ack,
    input  logic [WB_DW-1:0]  mem_rdata
);
    typedef struct packed {
        wb_entry_t [DEPTH-1:0] ent;
        logic [PTRW-1:0]       head;
        logic [CNTW-1:0]       cnt;
    } state_t;

    state_t s_q, s_d;
    logic [CNTW-1:0] cnt_q;
    logic any_match, full_cover, rd_go, drain_done, full;
    logic [WB_DW-1:0] fwd_data;

    assign cnt_q = s_q.cnt;
    assign full  = (s_q.cnt == CNTW'(DEPTH));

    wrbuf_lookup #(.DEPTH(DEPTH)) u_lookup (
        .ent        (s_q.ent),
        .head       (s_q.head),
        .cnt        (s_q.cnt),
        .rd_addr    (rd_addr),
        .any_match  (any_match),
        .full_cover (full_cover),
        .fwd_data   (fwd_data)
    );

    wrbuf_port_arb u_arb (
        .rd_valid   (rd_valid),
        .rd_match   (any_match),
        .rd_addr    (rd_addr),
        .have_entry (s_q.cnt != '0),
        .head_ent   (s_q.ent[s_q.head]),
        .mem_ack    (mem_ack),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_be     (mem_be),
        .rd_go      (rd_go),
        .drain_done (drain_done)
    );

    always_comb begin
        logic [PTRW-1:0] tail;
        logic            fwd;
        s_d  = s_q;
        tail = s_q.head + PTRW'(s_q.cnt);
        if (drain_done) begin
            s_d.head = s_q.head + PTRW'(1);
        end
        if (wr_valid && !full) begin
            s_d.ent[tail] = '{addr: wr_addr, data: wr_data, be: wr_be};
        end
        s_d.cnt = s_q.cnt + CNTW'(wr_valid && !full) - CNTW'(drain_done);

        fwd      = rd_valid && any_match && full_cover;
        rd_wait  = rd_valid && any_match && !full_cover;
        rd_ack   = fwd || (rd_go && mem_ack);
        rd_data  = fwd ? fwd_data : mem_rdata;
        wr_stall = full;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/wrbuf_chk.sv
module wrbuf_chk
    import wrbuf_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int CNTW = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_stall,
    input logic             rd_valid,
    input logic             rd_wait,
    input logic             rd_ack,
    input logic [WB_AW-1:0] rd_addr,
    input logic             mem_req,
    input logic             mem_we,
    input logic             mem_ack,
    input logic [WB_AW-1:0] mem_addr,
    input logic [CNTW-1:0]  cnt
);
    // R1
    empty_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0 && !rd_valid) |-> !mem_req);
    // R2
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNTW'(DEPTH));
    // R2
    drain_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && !mem_ack) |=> (rd_valid || (mem_req && mem_we && $stable(mem_addr))));
    // R3
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stall && !(mem_req && mem_we && mem_ack)) |=> wr_stall);
    // R6
    wait_no_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_wait |-> !rd_ack);
    // R7
    read_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we) |-> (rd_valid && !rd_wait && mem_addr == rd_addr));
endmodule

bind wr_drain_buf wrbuf_chk #(.DEPTH(DEPTH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_stall (wr_stall),
    .rd_valid (rd_valid),
    .rd_wait  (rd_wait),
    .rd_ack   (rd_ack),
    .rd_addr  (rd_addr),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_ack  (mem_ack),
    .mem_addr (mem_addr),
    .cnt      (cnt_q)
);

// File: tb/wr_drain_buf_tb.sv
module wr_drain_buf_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid = 1'b0;
    logic [31:0] wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [3:0]  wr_be = '0;
    logic        wr_stall;
    logic        rd_valid = 1'b0;
    logic [31:0] rd_addr = '0;
    logic        rd_ack, rd_wait;
    logic [31:0] rd_data;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [3:0]  mem_be;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    logic [31:0] log_addr [16];
    logic [31:0] log_data [16];
    logic [3:0]  log_be   [16];
    int log_n = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] rmodel(logic [31:0] a);
        return a ^ 32'h5A5A_0F0F;
    endfunction
    assign mem_rdata = rmodel(mem_addr);

    wr_drain_buf u_dut (
        .clk(clk), .rst_n(rst_n),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data), .wr_be(wr_be),
        .wr_stall(wr_stall),
        .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_wait(rd_wait),
        .rd_data(rd_data),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_be(mem_be), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    // completed drains, observed mid-cycle
    always @(negedge clk) begin
        if (rst_n && mem_req && mem_we && mem_ack && log_n < 16) begin
            log_addr[log_n] = mem_addr;
            log_data[log_n] = mem_wdata;
            log_be[log_n]   = mem_be;
            log_n = log_n + 1;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic push(input logic [31:0] a, input logic [31:0] d, input logic [3:0] be);
        wr_valid = 1'b1; wr_addr = a; wr_data = d; wr_be = be;
        @(posedge clk); #1;
        wr_valid = 1'b0;
    endtask

    task automatic drain_all(input int expect_n);
        mem_ack = 1'b1;
        for (int i = 0; i < 20 && log_n < expect_n; i++) begin
            @(posedge clk); #1;
        end
        repeat (3) @(posedge clk);
        #1;
        mem_ack = 1'b0;
    endtask

    task automatic t_reset;
        @(negedge clk);
        check(wr_stall == 1'b0, "R1 stall", {31'b0, wr_stall}, 0);
        check(mem_req == 1'b0, "R1 mem_req", {31'b0, mem_req}, 0);
        check(!rd_ack && !rd_wait, "R1 rd", {30'b0, rd_ack, rd_wait}, 0);
        @(posedge clk); #1;
    endtask

    task automatic t_order;
        log_n = 0;
        push(32'h100, 32'h1111_0001, 4'hF);
        push(32'h104, 32'h2222_0002, 4'h3);
        push(32'h100, 32'h3333_0003, 4'hF);
        @(negedge clk);
        check(mem_req && mem_we && mem_addr == 32'h100, "R2 head presented", mem_addr, 32'h100);
        @(posedge clk); #1;
        drain_all(3);
        check(log_n == 3, "R4 no merge count", log_n, 3);
        check(log_addr[0] == 32'h100 && log_data[0] == 32'h1111_0001, "R2 order 0", log_data[0], 32'h1111_0001);
        check(log_addr[1] == 32'h104 && log_data[1] == 32'h2222_0002 && log_be[1] == 4'h3, "R2 order 1", log_data[1], 32'h2222_0002);
        check(log_addr[2] == 32'h100 && log_data[2] == 32'h3333_0003, "R4 second same-address", log_data[2], 32'h3333_0003);
    endtask

    task automatic t_full;
        log_n = 0;
        for (int i = 0; i < 4; i++) push(32'h200 + 32'(i*4), 32'hA000_0000 + 32'(i), 4'hF);
        @(negedge clk);
        check(wr_stall == 1'b1, "R3 stall when full", {31'b0, wr_stall}, 1);
        @(posedge clk); #1;
        push(32'h2F0, 32'hDEAD_BEEF, 4'hF);
        push(32'h2F0, 32'hDEAD_BEEF, 4'hF);
        @(negedge clk);
        check(wr_stall == 1'b1, "R3 stall held", {31'b0, wr_stall}, 1);
        @(posedge clk); #1;
        drain_all(5);
        check(log_n == 4, "R3 dropped write", log_n, 4);
        check(log_data[3] == 32'hA000_0003, "R3 last drain", log_data[3], 32'hA000_0003);
        @(negedge clk);
        check(!wr_stall && !mem_req, "R3 empty after drain", {30'b0, wr_stall, mem_req}, 0);
        @(posedge clk); #1;
    endtask

    task automatic t_forward;
        log_n = 0;
        push(32'h300, 32'h0000_0010, 4'hF);
        push(32'h300, 32'h0000_0020, 4'hF);
        push(32'h308, 32'h0000_0030, 4'h3);
        push(32'h308, 32'h0000_0040, 4'hF);
        rd_valid = 1'b1; rd_addr = 32'h300;
        @(negedge clk);
        check(rd_ack && !rd_wait && rd_data == 32'h20, "R5 youngest full", rd_data, 32'h20);
        check(!(mem_req && !mem_we), "R5 no mem read", {31'b0, mem_req && !mem_we}, 0);
        @(posedge clk); #1;
        rd_addr = 32'h308;
        @(negedge clk);
        check(rd_ack && !rd_wait && rd_data == 32'h40, "R5 younger full over older partial", rd_data, 32'h40);
        @(posedge clk); #1;
        rd_valid = 1'b0;
        drain_all(4);
    endtask

    task automatic t_partial;
        bit cleared = 1'b0;
        log_n = 0;
        push(32'h400, 32'h0000_0050, 4'hF);
        push(32'h400, 32'h0000_0051, 4'h1);
        rd_valid = 1'b1; rd_addr = 32'h400;
        @(negedge clk);
        check(rd_wait && !rd_ack, "R6 partial waits", {30'b0, rd_wait, rd_ack}, 2);
        check(mem_req && mem_we && mem_addr == 32'h400, "R8 drain continues", mem_addr, 32'h400);
        @(posedge clk); #1;
        mem_ack = 1'b1;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (!rd_wait) begin cleared = 1'b1; break; end
            @(posedge clk); #1;
        end
        check(cleared && log_n == 2, "R6 waits until both drained", log_n, 2);
        check(rd_ack && mem_req && !mem_we && rd_data == rmodel(32'h400), "R6 then memory read", rd_data, rmodel(32'h400));
        @(posedge clk); #1;
        rd_valid = 1'b0; mem_ack = 1'b0;
    endtask

    task automatic t_priority;
        log_n = 0;
        push(32'h500, 32'h0000_0060, 4'hF);
        push(32'h504, 32'h0000_0061, 4'hF);
        rd_valid = 1'b1; rd_addr = 32'h5F0;
        @(negedge clk);
        check(mem_req && !mem_we && mem_addr == 32'h5F0, "R7 read beats drain", mem_addr, 32'h5F0);
        check(!rd_ack, "R7 no ack without mem_ack", {31'b0, rd_ack}, 0);
        @(posedge clk); #1;
        mem_ack = 1'b1;
        @(negedge clk);
        check(rd_ack && rd_data == rmodel(32'h5F0), "R7 data from memory", rd_data, rmodel(32'h5F0));
        check(log_n == 0, "R7 no drain during read", log_n, 0);
        @(posedge clk); #1;
        rd_valid = 1'b0;
        drain_all(2);
        check(log_n == 2, "R7 drains resume", log_n, 2);
    endtask

    task automatic t_same_cycle;
        log_n = 0;
        wr_valid = 1'b1; wr_addr = 32'h600; wr_data = 32'h0000_0070; wr_be = 4'hF;
        rd_valid = 1'b1; rd_addr = 32'h600;
        @(negedge clk);
        check(mem_req && !mem_we && !rd_wait, "R9 new write unseen", {30'b0, mem_req, mem_we}, 2);
        @(posedge clk); #1;
        wr_valid = 1'b0;
        @(negedge clk);
        check(rd_ack && rd_data == 32'h70, "R9 visible next cycle", rd_data, 32'h70);
        @(posedge clk); #1;
        rd_valid = 1'b0;
        drain_all(1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        t_reset();
        t_order();
        t_full();
        t_forward();
        t_partial();
        t_priority();
        t_same_cycle();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule